// File: doc/BRIEF.md
# Two-Wire Slave Command Decoder

This block is the bus-facing half of a dual-channel digital trimmer. It watches a two-wire serial bus (clock line and open-drain data line) with a fast system clock. It recognises start, repeated start and stop conditions, and it answers only to its own seven-bit address. The top five bits of that address are fixed. The low two bits come from a pair of board straps. A write carries an instruction byte and then any number of data bytes. A read returns a single code from the channel chosen by the most recent write.

The decoder holds the decoded instruction fields as levels and pulses `instr_stb` when an instruction byte is complete. It pulses `load_stb` with the code and channel for every data byte. It reports the selected channel on `sel_chan`, so that the neighbouring wiper-register block can return that channel's code on `rd_code`. The decoder never drives the data line high: `sda_pull` high means "pull the line low".

The controller uses these states: `ST_IDLE`, `ST_ADDR` (address bits), `ST_ADDR_ACK`, `ST_INSTR`, `ST_INSTR_ACK`, `ST_DATA`, `ST_DATA_ACK`, `ST_READ` (bits sent out), `ST_READ_ACK` (master acknowledge slot) and `ST_SKIP` (not addressed). The transitions are as follows:
- A start from any state leads to `ST_ADDR`, and a stop from any state leads to `ST_IDLE`.
- At the eighth address bit the controller goes to `ST_ADDR_ACK` on a match and to `ST_SKIP` otherwise.
- Each acknowledge state leaves on the clock fall that ends the ninth bit. From `ST_ADDR_ACK` it goes to `ST_READ` or `ST_INSTR`. From `ST_INSTR_ACK` and `ST_DATA_ACK` it goes to `ST_DATA`.
- `ST_READ` goes to `ST_READ_ACK` after eight bits. `ST_READ_ACK` returns to `ST_READ` on a master acknowledge and goes to `ST_SKIP` on a not-acknowledge.

Top module: `twowire_cmd_slave`

## Requirements
- R1: The address byte is matched MSB first against 0,1,0,1,1, then `strap_addr[1]`, then `strap_addr[0]`. Its last bit selects the direction: 1 is a read and 0 is a write. Only an exact match is acknowledged.
- R2: A start is a falling data line while the clock is high, and a stop is a rising data line while the clock is high. A stop abandons a partly received byte without any strobe. A later start begins a fresh address.
- R3: For each accepted byte, the slave pulls the data line low through the ninth clock pulse and releases it after that pulse ends.
- R4: Instruction byte fields: bit 7 selects the channel (0 is the first channel, 1 is the second), bit 6 is midscale reset, bit 5 is shutdown, bit 4 is output one and bit 3 is output two. Bits 2..0 are ignored. At the eighth bit the fields update and `instr_stb` pulses for one cycle. `sel_chan` changes only together with that pulse.
- R5: Each data byte after the instruction pulses `load_stb` for one cycle with the byte on `load_code` and the selected channel on `load_chan`. Further data bytes before a stop load the same channel again.
- R6: A stop right after the instruction byte updates the fields and gives no `load_stb`.
- R7: A read sends `rd_code`, MSB first, starting right after the address acknowledge. It releases the line after the eighth bit, and a master not-acknowledge ends the transfer.
- R8: A repeated start after only the instruction byte may switch straight into a read. That read returns the code of the newly selected channel, with no load.
- R9: After reset the line is released, all fields and `sel_chan` are 0, and no strobe is active.
- R10: After an address mismatch, the slave does not pull the line at all until the next start or stop.
- R11: The slave changes its pull only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_pull | output | 1 | 1 pulls the data line low |
| strap_addr | input | 2 | Address straps, bit 1 then bit 0 in the address |
| rd_code | input | 8 | Code of the selected channel from the wiper block |
| sel_chan | output | 1 | Channel chosen by the last instruction |
| instr_stb | output | 1 | One-cycle pulse when an instruction byte is complete |
| mid_rst | output | 1 | Held midscale-reset field |
| shdn | output | 1 | Held shutdown field |
| out1 | output | 1 | Held output-one field |
| out2 | output | 1 | Held output-two field |
| load_stb | output | 1 | One-cycle pulse per data byte |
| load_chan | output | 1 | Channel for the load |
| load_code | output | 8 | Code to load |

## Verification
The bench sends addresses that differ only in the strap bits and addresses that differ only in the fixed bits. A decoder that compared the wrong bits would acknowledge one of them, or would drive the data line while it is skipping bytes. It switches from write to read with a repeated start and no data byte. A design that kept the old channel, or issued a spurious load, returns the wrong code. It also ends a write after the instruction byte, and cuts off an instruction with a stop after five bits. A design that counted bits across the stop, or loaded on any strobe, shows a stray `load_stb` or `instr_stb`. A second data byte in one write exposes a design that drops back to the instruction state.

// File: rtl/tws_pkg.sv
package tws_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_INSTR,
        ST_INSTR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_READ,
        ST_READ_ACK,
        ST_SKIP
    } tws_state_e;

    // Bit positions inside the instruction byte (decoded downstream).
    localparam int INS_CHAN_BIT = 7;
    localparam int INS_MRST_BIT = 6;
    localparam int INS_SHDN_BIT = 5;
    localparam int INS_OUT1_BIT = 4;
    localparam int INS_OUT2_BIT = 3;

    typedef struct packed {
        logic chan;
        logic mid_rst;
        logic shdn;
        logic out1;
        logic out2;
    } tws_instr_t;

    function automatic tws_instr_t decode_instr(input logic [DATA_W-1:0] b);
        tws_instr_t r;
        r.chan    = b[INS_CHAN_BIT];
        r.mid_rst = b[INS_MRST_BIT];
        r.shdn    = b[INS_SHDN_BIT];
        r.out1    = b[INS_OUT1_BIT];
        r.out2    = b[INS_OUT2_BIT];
        return r;
    endfunction

endpackage

// File: rtl/tws_line_sync.sv
module tws_line_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{RESET_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/tws_bus_cond.sv
module tws_bus_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] lvl;
    logic [LINES-1:0] prev;

    assign raw = {sda_in, scl_in};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        tws_line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (raw[g]),
            .q     (lvl[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev <= '1;
        end else begin
            prev <= lvl;
        end
    end

    assign scl_lvl   = lvl[0];
    assign sda_lvl   = lvl[1];
    assign scl_rise  = lvl[0] & ~prev[0];
    assign scl_fall  = ~lvl[0] & prev[0];
    assign start_det = lvl[0] & prev[0] & prev[1] & ~lvl[1];
    assign stop_det  = lvl[0] & prev[0] & ~prev[1] & lvl[1];
endmodule

// File: rtl/tws_ctrl.sv
module tws_ctrl
    import tws_pkg::*;
#(
    parameter int           ID_W    = 5,
    parameter logic [ID_W-1:0] DEV_ID = 5'b01011,
    parameter int           STRAP_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [STRAP_W-1:0] strap,
    input  logic [DATA_W-1:0] rd_code,
    output logic              sda_pull,
    output tws_instr_t        instr,
    output logic              instr_stb,
    output logic              load_stb,
    output logic [DATA_W-1:0] load_code
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    tws_state_e        state, nstate;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] rx_byte;
    logic              rw_q;
    logic              ack_on;
    logic              mack_q;
    logic              last_bit;
    logic              addr_hit;

    assign rx_byte  = {rx_sh[DATA_W-2:0], sda_lvl};
    assign last_bit = (bit_cnt == LAST_BIT);
    assign addr_hit = (rx_byte[DATA_W-1 -: ID_W] == DEV_ID) &&
                      (rx_byte[STRAP_W:1] == strap);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nstate;
        end
    end

    // Next state
    always_comb begin
        nstate = state;
        if (stop_det) begin
            nstate = ST_IDLE;
        end else if (start_det) begin
            nstate = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:      nstate = ST_IDLE;
                ST_ADDR:      if (scl_rise && last_bit) nstate = addr_hit ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK:  if (scl_fall && ack_on)   nstate = rw_q ? ST_READ : ST_INSTR;
                ST_INSTR:     if (scl_rise && last_bit) nstate = ST_INSTR_ACK;
                ST_INSTR_ACK: if (scl_fall && ack_on)   nstate = ST_DATA;
                ST_DATA:      if (scl_rise && last_bit) nstate = ST_DATA_ACK;
                ST_DATA_ACK:  if (scl_fall && ack_on)   nstate = ST_DATA;
                ST_READ:      if (scl_fall && last_bit) nstate = ST_READ_ACK;
                ST_READ_ACK:  if (scl_fall)             nstate = mack_q ? ST_READ : ST_SKIP;
                ST_SKIP:      nstate = ST_SKIP;
                default:      nstate = ST_IDLE;
            endcase
        end
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            rw_q      <= 1'b0;
            ack_on    <= 1'b0;
            mack_q    <= 1'b0;
            sda_pull  <= 1'b0;
            instr     <= '0;
            instr_stb <= 1'b0;
            load_stb  <= 1'b0;
            load_code <= '0;
        end else begin
            instr_stb <= 1'b0;
            load_stb  <= 1'b0;
            if (start_det || stop_det) begin
                bit_cnt  <= '0;
                ack_on   <= 1'b0;
                sda_pull <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_INSTR, ST_DATA: begin
                        if (scl_rise) begin
                            rx_sh   <= rx_byte;
                            bit_cnt <= bit_cnt + 1'b1;
                            if (last_bit) begin
                                if (state == ST_ADDR) begin
                                    rw_q <= sda_lvl;
                                end else if (state == ST_INSTR) begin
                                    instr     <= decode_instr(rx_byte);
                                    instr_stb <= 1'b1;
                                end else begin
                                    load_code <= rx_byte;
                                    load_stb  <= 1'b1;
                                end
                            end
                        end
                    end
                    ST_ADDR_ACK, ST_INSTR_ACK, ST_DATA_ACK: begin
                        if (scl_fall) begin
                            if (!ack_on) begin
                                ack_on   <= 1'b1;
                                sda_pull <= 1'b1;
                            end else begin
                                ack_on   <= 1'b0;
                                bit_cnt  <= '0;
                                if (state == ST_ADDR_ACK && rw_q) begin
                                    tx_sh    <= rd_code;
                                    sda_pull <= ~rd_code[DATA_W-1];
                                end else begin
                                    sda_pull <= 1'b0;
                                end
                            end
                        end
                    end
                    ST_READ: begin
                        if (scl_fall) begin
                            if (last_bit) begin
                                sda_pull <= 1'b0;
                                bit_cnt  <= '0;
                            end else begin
                                tx_sh    <= {tx_sh[DATA_W-2:0], 1'b0};
                                sda_pull <= ~tx_sh[DATA_W-2];
                                bit_cnt  <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    ST_READ_ACK: begin
                        if (scl_rise) begin
                            mack_q <= ~sda_lvl;
                        end
                        if (scl_fall && mack_q) begin
                            tx_sh    <= rd_code;
                            sda_pull <= ~rd_code[DATA_W-1];
                        end
                    end
                    ST_IDLE, ST_SKIP: begin
                        sda_pull <= 1'b0;
                    end
                    default: begin
                        sda_pull <= 1'b0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/twowire_cmd_slave.sv
module twowire_cmd_slave
    import tws_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_pull,
    input  logic [1:0] strap_addr,
    input  logic [7:0] rd_code,
    output logic       sel_chan,
    output logic       instr_stb,
    output logic       mid_rst,
    output logic       shdn,
    output logic       out1,
    output logic       out2,
    output logic       load_stb,
    output logic       load_chan,
    output logic [7:0] load_code
);
    logic       scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    tws_instr_t instr;

    tws_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) i_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    tws_ctrl #(.ID_W(5), .DEV_ID(5'b01011), .STRAP_W(2)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .strap     (strap_addr),
        .rd_code   (rd_code),
        .sda_pull  (sda_pull),
        .instr     (instr),
        .instr_stb (instr_stb),
        .load_stb  (load_stb),
        .load_code (load_code)
    );

    assign sel_chan  = instr.chan;
    assign load_chan = instr.chan;
    assign mid_rst   = instr.mid_rst;
    assign shdn      = instr.shdn;
    assign out1      = instr.out1;
    assign out2      = instr.out2;

    logic unused_lvl;
    assign unused_lvl = scl_lvl;
endmodule

// File: rtl/tws_chk.sv
module tws_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_in,
    input logic sda_pull,
    input logic instr_stb,
    input logic load_stb,
    input logic sel_chan
);
    // R11
    pull_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull != $past(sda_pull)) |-> !scl_in);

    // R4
    instr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        instr_stb |=> !instr_stb);

    // R4
    chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_chan != $past(sel_chan)) |-> instr_stb);

    // R5
    load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> !load_stb);

    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        instr_stb |-> !load_stb);
endmodule

bind twowire_cmd_slave tws_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .sda_pull  (sda_pull),
    .instr_stb (instr_stb),
    .load_stb  (load_stb),
    .sel_chan  (sel_chan)
);

// File: tb/test_twowire_cmd_slave.sv
module test_twowire_cmd_slave;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 10;
    localparam logic [1:0] STRAP = 2'b10;
    localparam logic [7:0] ADR_W = {5'b01011, STRAP, 1'b0};
    localparam logic [7:0] ADR_R = {5'b01011, STRAP, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_bus;
    logic sda_pull, sel_chan, instr_stb, mid_rst, shdn, out1, out2, load_stb, load_chan;
    logic [7:0] load_code, rd_code;
    logic [7:0] wipe_a, wipe_b;

    int tests = 0, fails = 0;
    int n_load = 0, n_instr = 0, n_pull = 0, n_bad_edge = 0;
    logic [7:0] last_code;
    logic       last_chan;
    logic       prev_pull = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_bus = m_sda & ~sda_pull;
    assign rd_code = sel_chan ? wipe_b : wipe_a;

    twowire_cmd_slave i_twowire_cmd_slave (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus),
        .sda_pull(sda_pull), .strap_addr(STRAP), .rd_code(rd_code),
        .sel_chan(sel_chan), .instr_stb(instr_stb), .mid_rst(mid_rst),
        .shdn(shdn), .out1(out1), .out2(out2), .load_stb(load_stb),
        .load_chan(load_chan), .load_code(load_code)
    );

    // Wiper register model and event monitors
    always @(posedge clk) begin
        if (!rst_n) begin
            wipe_a <= 8'h80;
            wipe_b <= 8'h80;
        end else begin
            if (load_stb) begin
                n_load++;
                last_code <= load_code;
                last_chan <= load_chan;
                if (load_chan) wipe_b <= load_code;
                else           wipe_a <= load_code;
            end
            if (instr_stb) n_instr++;
            if (sda_pull) n_pull++;
            if (sda_pull != prev_pull && m_scl) n_bad_edge++;
            prev_pull <= sda_pull;
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        m_sda = 1'b1; wt(Q);
        m_scl = 1'b1; wt(Q);
        m_sda = 1'b0; wt(Q);
        m_scl = 1'b0; wt(Q);
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; wt(Q);
        m_scl = 1'b1; wt(Q);
        m_sda = 1'b1; wt(Q);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; wt(Q);
        m_scl = 1'b1; wt(Q);
        m_scl = 1'b0; wt(Q);
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; wt(Q);
        m_scl = 1'b1; wt(Q/2);
        b = sda_bus; wt(Q/2);
        m_scl = 1'b0; wt(Q);
    endtask

    task automatic write_byte(input logic [7:0] d, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        get_bit(a);
        ack = ~a;
    endtask

    task automatic read_byte(input logic mack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        send_bit(~mack);
    endtask

    task automatic t_reset;
        chk("R9 pull released", sda_pull, 0);
        chk("R9 channel", sel_chan, 0);
        chk("R9 fields", {mid_rst, shdn, out1, out2}, 0);
        chk("R9 strobes", {instr_stb, load_stb}, 0);
    endtask

    task automatic t_write_two;
        logic a;
        int l0, i0;
        l0 = n_load; i0 = n_instr;
        bus_start;
        write_byte(ADR_W, a);  chk("R1 R3 write address ack", a, 1);
        write_byte(8'hB7, a);  chk("R3 instruction ack", a, 1);
        chk("R4 instruction strobe", n_instr - i0, 1);
        chk("R4 fields chan/mrst/shdn/o1/o2", {sel_chan, mid_rst, shdn, out1, out2}, 5'b10110);
        write_byte(8'h5A, a);  chk("R3 data ack", a, 1);
        chk("R5 first load code", last_code, 8'h5A);
        write_byte(8'hC3, a);
        bus_stop;
        chk("R5 two loads", n_load - l0, 2);
        chk("R5 repeat load code", last_code, 8'hC3);
        chk("R5 repeat load channel", last_chan, 1);
    endtask

    task automatic t_instr_only;
        logic a;
        int l0, i0;
        l0 = n_load; i0 = n_instr;
        bus_start;
        write_byte(ADR_W, a);
        write_byte(8'h4F, a);
        bus_stop;
        wt(4);
        chk("R6 instruction strobe", n_instr - i0, 1);
        chk("R6 no load", n_load - l0, 0);
        chk("R4 R6 fields (low bits ignored)", {sel_chan, mid_rst, shdn, out1, out2}, 5'b01001);
    endtask

    task automatic t_read_back;
        logic a;
        logic [7:0] d;
        bus_start;
        write_byte(ADR_W, a);
        write_byte(8'h00, a);
        write_byte(8'h33, a);
        bus_stop;
        bus_start;
        write_byte(ADR_R, a);  chk("R1 read address ack", a, 1);
        read_byte(1'b0, d);
        chk("R7 read code channel one", d, 8'h33);
        chk("R7 released after nack", sda_pull, 0);
        bus_stop;
    endtask

    task automatic t_rstart;
        logic a;
        logic [7:0] d;
        int l0;
        l0 = n_load;
        bus_start;
        write_byte(ADR_W, a);
        write_byte(8'h80, a);
        bus_start;
        write_byte(ADR_R, a);  chk("R8 read ack after repeated start", a, 1);
        read_byte(1'b0, d);
        bus_stop;
        chk("R8 code of new channel", d, 8'hC3);
        chk("R8 no load", n_load - l0, 0);
    endtask

    task automatic t_mismatch;
        logic a;
        int p0, l0;
        p0 = n_pull; l0 = n_load;
        bus_start;
        write_byte({5'b01011, 2'b01, 1'b0}, a);  chk("R1 wrong strap nack", a, 0);
        write_byte(8'h00, a);
        write_byte(8'h00, a);
        bus_stop;
        bus_start;
        write_byte({5'b00011, STRAP, 1'b0}, a);  chk("R1 wrong fixed bits nack", a, 0);
        write_byte(ADR_W, a);
        bus_stop;
        chk("R10 no pull while skipping", n_pull - p0, 0);
        chk("R10 no load while skipping", n_load - l0, 0);
    endtask

    task automatic t_stop_midbyte;
        logic a;
        int i0;
        i0 = n_instr;
        bus_start;
        write_byte(ADR_W, a);
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        bus_stop;
        chk("R2 partial byte discarded", n_instr - i0, 0);
        bus_start;
        write_byte(ADR_W, a);  chk("R2 fresh address after stop", a, 1);
        write_byte(8'h00, a);
        bus_stop;
        chk("R2 fresh instruction applied", n_instr - i0, 1);
        chk("R11 pull changes only with clock low", n_bad_edge, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        wt(5);
        t_reset;
        rst_n = 1'b1;
        wt(5);
        t_reset;
        t_write_two;
        t_instr_only;
        t_read_back;
        t_rstart;
        t_mismatch;
        t_stop_midbyte;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule